// File: doc/BRIEF.md
# Buck Switching Cycle Timer

This block produces the gate drive for a peak-current-mode buck converter one switching cycle at a time. It reads three comparator flags that are already digital: the current limit, the over-current trip and the inductor zero-cross. It also reads a feedback-derived off-time given as a clock-cycle count. The drive opens when the current limit is reached once the leading-edge blanking window has passed, or when the on-time cap expires. An over-current trip after blanking stops switching until the block is stopped and started again.

The drive closes again at the latest of three off-time sources, clamped between a minimum and a maximum off-time. The first is the valley event, raised a fixed delay after the zero-cross. The second is the feedback off-time, captured at turn-off. The third is a soft-start term that is loaded with the maximum off-time at every start and shrinks by a fixed step per cycle. Because the latest source wins, the converter moves between valley-switched (quasi-resonant) and discontinuous operation without any mode input. A flag reports which source set the last turn-on.

There is no data stream at the edge of this block. The off-time count is a level that the block samples and never acknowledges, so there is no valid/ready handshake and no back-pressure. All pins are plain control and status.

Top module: `buck_cycle_timer`

## Requirements
- R1: While reset is low or stop is high, the gate, the fault flag and the mode flag are 0. After reset is released the gate stays 0 until a start edge.
- R2: A rising edge on start, seen while stop is low and the block is idle or faulted, sets the gate high on the next clock. It also reloads the soft-start term to TOFF_MAX_CYC.
- R3: The current-limit flag is ignored during the first LEB_CYC cycles of each on-time. With the flag held high, the on-time is therefore exactly LEB_CYC+1 cycles.
- R4: If the current limit is never reached, the gate is forced low after TON_MAX_CYC cycles of on-time.
- R5: The over-current flag is ignored during blanking. After blanking it drops the gate, raises the fault flag and holds the gate low until stop is raised. It takes precedence over the current limit in the same cycle.
- R6: Off-cycles are counted from 0 at turn-off. A zero-cross seen in off-cycle k raises the valley event at an off-time of k+QR_DLY_CYC cycles. When that event is the latest source, the off-time equals it and the mode flag reads 1.
- R7: When the feedback off-time is the latest source, the off-time equals the feedback count and the mode flag reads 0.
- R8: The off-time is never shorter than TOFF_MIN_CYC cycles, even when all sources are shorter.
- R9: The off-time is never longer than TOFF_MAX_CYC cycles. When no zero-cross arrives, the off-time is exactly TOFF_MAX_CYC.
- R10: After a start, off-period n (counted from 1) has a floor of TOFF_MAX_CYC-(n-1)*SS_STEP_CYC, saturating at 0. Once the term reaches 0 it no longer affects the off-time.
- R11: The feedback count is sampled at the turn-off edge. Changes to it during the off-time do not alter that off-time.
- R12: While stop is high the gate stays low whatever the comparator flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, acted on at its rising edge |
| stop_i | input | 1 | Level stop: holds the gate low and clears the counters |
| cs_limit_i | input | 1 | Current-limit comparator flag |
| ocp_i | input | 1 | Over-current comparator flag |
| zc_i | input | 1 | Inductor zero-cross flag |
| fb_toff_i | input | CW | Feedback off-time in clock cycles |
| gate_o | output | 1 | Switch gate drive |
| qr_mode_o | output | 1 | 1 when the last turn-on was set by the valley event |
| ocp_fault_o | output | 1 | Over-current shutdown active |

## Verification
Every output comes straight from a flop. A start edge or flag seen at clock edge t therefore shows on the pins right after t, and the mode flag changes at the same edge that raises the gate. The bench drives and samples on falling edges. It measures on-time and off-time as the number of falling-edge samples that see the gate high or low, which gives exact cycle counts. Each zero-cross is placed at a known off-sample index k, so the valley off-time it expects is k+QR_DLY_CYC. Each soft-start off-period is predicted from its position after the start edge.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ON    = 2'd1,
    PH_OFF   = 2'd2,
    PH_FAULT = 2'd3
  } phase_t;
endpackage

// File: rtl/bct_soft_start.sv
module bct_soft_start #(
  parameter int CW           = 16,
  parameter int TOFF_MAX_CYC = 65,
  parameter int SS_STEP_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_i,
  input  logic          step_i,
  output logic [CW-1:0] ss_o
);
  localparam logic [CW-1:0] SS_TOP  = CW'(TOFF_MAX_CYC);
  localparam logic [CW-1:0] SS_STEP = CW'(SS_STEP_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ss_o <= SS_TOP;
    else if (reload_i)   ss_o <= SS_TOP;
    else if (step_i)     ss_o <= (ss_o > SS_STEP) ? ss_o - SS_STEP : '0;
  end

  // R10: the term never grows except on a reload
  p_ss_nonrise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_i |=> ss_o <= $past(ss_o));
endmodule

// File: rtl/bct_off_select.sv
module bct_off_select #(
  parameter int CW           = 16,
  parameter int TOFF_MIN_CYC = 62,
  parameter int TOFF_MAX_CYC = 65,
  parameter int QR_DLY_CYC   = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic [CW-1:0] off_cnt_i,
  input  logic [CW-1:0] fb_lat_i,
  input  logic [CW-1:0] ss_i,
  input  logic          zc_i,
  output logic          turn_on_o,
  output logic          qr_win_o
);
  localparam int AW = CW + 1;
  localparam logic [AW-1:0] MIN_X = AW'(TOFF_MIN_CYC);
  localparam logic [AW-1:0] MAX_X = AW'(TOFF_MAX_CYC);
  localparam logic [AW-1:0] QRD_X = AW'(QR_DLY_CYC);

  logic          zc_seen_q;
  logic [AW-1:0] qr_at_q;
  logic [AW-1:0] cnt_x, fb_x, ss_x;
  logic [AW-1:0] floor_a, floor_b, qr_eff, late, target;
  logic          zc_eff;

  assign cnt_x = {1'b0, off_cnt_i};
  assign fb_x  = {1'b0, fb_lat_i};
  assign ss_x  = {1'b0, ss_i};

  // valley event time, captured at the first zero-cross of the off period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_seen_q <= 1'b0;
      qr_at_q   <= '0;
    end else if (!active_i) begin
      zc_seen_q <= 1'b0;
      qr_at_q   <= '0;
    end else if (zc_i && !zc_seen_q) begin
      zc_seen_q <= 1'b1;
      qr_at_q   <= cnt_x + QRD_X;
    end
  end

  always_comb begin
    zc_eff  = zc_seen_q | (active_i & zc_i);
    qr_eff  = zc_seen_q ? qr_at_q : cnt_x + QRD_X;
    floor_a = (fb_x > MIN_X) ? fb_x : MIN_X;
    floor_b = (ss_x > floor_a) ? ss_x : floor_a;
    late    = (qr_eff > floor_b) ? qr_eff : floor_b;
    if (!zc_eff)            target = MAX_X;
    else if (late > MAX_X)  target = MAX_X;
    else                    target = late;
    turn_on_o = active_i & ((cnt_x + AW'(1)) >= target);
    qr_win_o  = zc_eff & (qr_eff >= floor_b);
  end
endmodule

// File: rtl/bct_phase_ctl.sv
module bct_phase_ctl
  import bct_pkg::*;
#(
  parameter int CW           = 16,
  parameter int LEB_CYC      = 20,
  parameter int TON_MAX_CYC  = 2500,
  parameter int TOFF_MIN_CYC = 62,
  parameter int TOFF_MAX_CYC = 65
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          cs_limit_i,
  input  logic          ocp_i,
  input  logic [CW-1:0] fb_toff_i,
  input  logic          turn_on_i,
  input  logic          qr_win_i,
  output logic          off_active_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] fb_lat_o,
  output logic          ss_reload_o,
  output logic          ss_step_o,
  output logic          gate_o,
  output logic          qr_mode_o,
  output logic          ocp_fault_o
);
  localparam logic [CW-1:0] LEB_C  = CW'(LEB_CYC);
  localparam logic [CW-1:0] TON_LC = CW'(TON_MAX_CYC - 1);

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;
  logic          start_q, start_rise, unblanked, idle_like;

  assign start_rise   = start_i & ~start_q;
  assign unblanked    = cnt_q >= LEB_C;
  assign idle_like    = (ph_q == PH_IDLE) || (ph_q == PH_FAULT);
  assign ss_reload_o  = !stop_i && start_rise && idle_like;
  assign ss_step_o    = !stop_i && (ph_q == PH_OFF) && turn_on_i;
  assign off_active_o = (ph_q == PH_OFF);
  assign cnt_o        = cnt_q;
  assign gate_o       = (ph_q == PH_ON);
  assign ocp_fault_o  = (ph_q == PH_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      fb_lat_o  <= '0;
      qr_mode_o <= 1'b0;
    end else if (stop_i) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      qr_mode_o <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE, PH_FAULT: begin
          if (start_rise) begin
            ph_q  <= PH_ON;
            cnt_q <= '0;
          end
        end
        PH_ON: begin
          if (unblanked && ocp_i) begin
            ph_q  <= PH_FAULT;
            cnt_q <= '0;
          end else if ((unblanked && cs_limit_i) || cnt_q == TON_LC) begin
            ph_q     <= PH_OFF;
            cnt_q    <= '0;
            fb_lat_o <= fb_toff_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_OFF: begin
          if (turn_on_i) begin
            ph_q      <= PH_ON;
            cnt_q     <= '0;
            qr_mode_o <= qr_win_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R3: the flags cannot end an on-time inside the blanking window
  p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ON && cnt_q < LEB_C && !stop_i) |=> ph_q == PH_ON);
  // R4: on-time never passes its cap
  p_ton_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_ON |-> cnt_q <= TON_LC);
  // R8: a turn-on request never comes before the minimum off-time
  p_off_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_OFF && turn_on_i) |-> (cnt_q + 1'b1) >= CW'(TOFF_MIN_CYC));
  // R9: off-time never runs past the maximum
  p_off_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_OFF |-> cnt_q < CW'(TOFF_MAX_CYC));
  // R12: stop forces the gate low on the next cycle
  p_stop_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !gate_o && cnt_q == '0);
endmodule

// File: rtl/buck_cycle_timer.sv
module buck_cycle_timer #(
  parameter int CW           = 16,
  parameter int LEB_CYC      = 20,
  parameter int TON_MAX_CYC  = 2500,
  parameter int QR_DLY_CYC   = 25,
  parameter int TOFF_MIN_CYC = 62,
  parameter int TOFF_MAX_CYC = 65,
  parameter int SS_STEP_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          cs_limit_i,
  input  logic          ocp_i,
  input  logic          zc_i,
  input  logic [CW-1:0] fb_toff_i,
  output logic          gate_o,
  output logic          qr_mode_o,
  output logic          ocp_fault_o
);
  logic          off_active, turn_on, qr_win, ss_reload, ss_step;
  logic [CW-1:0] cnt, fb_lat, ss_term;

  bct_phase_ctl #(
    .CW(CW), .LEB_CYC(LEB_CYC), .TON_MAX_CYC(TON_MAX_CYC),
    .TOFF_MIN_CYC(TOFF_MIN_CYC), .TOFF_MAX_CYC(TOFF_MAX_CYC)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .cs_limit_i(cs_limit_i), .ocp_i(ocp_i), .fb_toff_i(fb_toff_i),
    .turn_on_i(turn_on), .qr_win_i(qr_win), .off_active_o(off_active),
    .cnt_o(cnt), .fb_lat_o(fb_lat), .ss_reload_o(ss_reload),
    .ss_step_o(ss_step), .gate_o(gate_o), .qr_mode_o(qr_mode_o),
    .ocp_fault_o(ocp_fault_o)
  );

  bct_off_select #(
    .CW(CW), .TOFF_MIN_CYC(TOFF_MIN_CYC), .TOFF_MAX_CYC(TOFF_MAX_CYC),
    .QR_DLY_CYC(QR_DLY_CYC)
  ) u_offsel (
    .clk(clk), .rst_n(rst_n), .active_i(off_active), .off_cnt_i(cnt),
    .fb_lat_i(fb_lat), .ss_i(ss_term), .zc_i(zc_i),
    .turn_on_o(turn_on), .qr_win_o(qr_win)
  );

  bct_soft_start #(
    .CW(CW), .TOFF_MAX_CYC(TOFF_MAX_CYC), .SS_STEP_CYC(SS_STEP_CYC)
  ) u_ss (
    .clk(clk), .rst_n(rst_n), .reload_i(ss_reload), .step_i(ss_step),
    .ss_o(ss_term)
  );

  // R5: a fault can only begin from an on-time
  p_fault_from_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ocp_fault_o) |-> $past(gate_o));
endmodule

// File: tb/test_buck_cycle_timer.sv
`timescale 1ns/1ps
module test_buck_cycle_timer;
  localparam int CW = 16, LEB = 4, TONM = 40, QRD = 3, TMIN = 6, TMAX = 60, STEP = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic cs = 1'b0, ocp = 1'b0, zc = 1'b0;
  logic [CW-1:0] fb = '0;
  logic gate, qrm, flt;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  buck_cycle_timer #(.CW(CW), .LEB_CYC(LEB), .TON_MAX_CYC(TONM), .QR_DLY_CYC(QRD),
    .TOFF_MIN_CYC(TMIN), .TOFF_MAX_CYC(TMAX), .SS_STEP_CYC(STEP)) i_buck_cycle_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .cs_limit_i(cs),
    .ocp_i(ocp), .zc_i(zc), .fb_toff_i(fb), .gate_o(gate), .qr_mode_o(qrm),
    .ocp_fault_o(flt));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one switching cycle measured in falling-edge samples
  task automatic cycle(input int zc_at, input int cs_on, input int fb_mid,
                       input int ocp_lo, input int ocp_hi,
                       output int on_len, output int off_len);
    while (gate !== 1'b1) @(negedge clk);
    on_len = 0;
    while (gate === 1'b1 && on_len < 400) begin
      cs  = cs_on[0];
      ocp = (on_len >= ocp_lo && on_len <= ocp_hi);
      on_len++;
      @(negedge clk);
    end
    ocp = 1'b0;
    off_len = 0;
    while (gate === 1'b0 && off_len < 200) begin
      zc = (off_len == zc_at);
      if (off_len == 1 && fb_mid >= 0) fb = CW'(fb_mid);
      off_len++;
      @(negedge clk);
    end
    zc = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 gate in reset", gate, 0);
    chk("R1 fault in reset", flt, 0);
    chk("R1 mode in reset", qrm, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 gate idle after reset", gate, 0);
  endtask

  task automatic t_soft_start();
    int on_l, off_l;
    cs = 1'b1; fb = '0;
    do_start();
    chk("R2 gate high after start", gate, 1);
    for (int n = 1; n <= 4; n++) begin
      cycle(0, 1, -1, 999, -1, on_l, off_l);
      if (n == 1) chk("R3 blanked on-time", on_l, LEB + 1);
      chk($sformatf("R10 soft-start off %0d", n), off_l,
          (n < 4) ? TMAX - (n - 1) * STEP : TMIN);
    end
    chk("R8 mode after minimum off", qrm, 0);
  endtask

  task automatic t_qr();
    int on_l, off_l;
    fb = 10;
    cycle(12, 1, -1, 999, -1, on_l, off_l);
    chk("R6 valley off-time", off_l, 12 + QRD);
    chk("R6 mode valley", qrm, 1);
    cycle(20, 1, -1, 999, -1, on_l, off_l);
    chk("R6 late valley off-time", off_l, 20 + QRD);
  endtask

  task automatic t_dcm();
    int on_l, off_l;
    fb = 30;
    cycle(2, 1, -1, 999, -1, on_l, off_l);
    chk("R7 feedback off-time", off_l, 30);
    chk("R7 mode feedback", qrm, 0);
    fb = 2;
    cycle(0, 1, -1, 999, -1, on_l, off_l);
    chk("R8 floor off-time", off_l, TMIN);
  endtask

  task automatic t_max();
    int on_l, off_l;
    fb = 10;
    cycle(-1, 1, -1, 999, -1, on_l, off_l);
    chk("R9 no zero-cross off-time", off_l, TMAX);
    chk("R9 mode no zero-cross", qrm, 0);
    fb = 100;
    cycle(0, 1, -1, 999, -1, on_l, off_l);
    chk("R9 capped feedback", off_l, TMAX);
  endtask

  task automatic t_fb_sample();
    int on_l, off_l;
    fb = 20;
    cycle(0, 1, 50, 999, -1, on_l, off_l);
    chk("R11 sampled feedback", off_l, 20);
    fb = 0;
  endtask

  task automatic t_ton_max();
    int on_l, off_l;
    fb = 0;
    cycle(0, 0, -1, 999, -1, on_l, off_l);
    chk("R4 on-time cap", on_l, TONM);
    cs = 1'b1;
  endtask

  task automatic t_ocp();
    int on_l, off_l;
    cycle(0, 1, -1, 0, LEB - 1, on_l, off_l);
    chk("R5 blanked ocp on-time", on_l, LEB + 1);
    chk("R5 blanked ocp no fault", flt, 0);
    cycle(0, 1, -1, LEB, 999, on_l, off_l);
    chk("R5 ocp on-time", on_l, LEB + 1);
    chk("R5 fault flag", flt, 1);
    chk("R5 gate held low", off_l, 200);
    stop = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 fault cleared by stop", flt, 0);
  endtask

  task automatic t_stop();
    int on_l, off_l, highs;
    stop = 1'b0;
    do_start();
    cycle(0, 1, -1, 999, -1, on_l, off_l);
    chk("R2 reloaded soft start", off_l, TMAX);
    @(negedge clk);
    stop = 1'b1; cs = 1'b0; zc = 1'b1;
    @(negedge clk);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      if (gate) highs++;
      @(negedge clk);
    end
    chk("R12 gate low under stop", highs, 0);
    chk("R1 mode under stop", qrm, 0);
    zc = 1'b0; stop = 1'b0; cs = 1'b1;
    do_start();
    chk("R2 restart after stop", gate, 1);
    cycle(0, 1, -1, 999, -1, on_l, off_l);
    chk("R2 soft start on restart", off_l, TMAX);
  endtask

  initial begin
    t_reset();
    t_soft_start();
    t_qr();
    t_dcm();
    t_max();
    t_fb_sample();
    t_ton_max();
    t_ocp();
    t_stop();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule